// File: doc/BRIEF.md
# Serial Clock and Parameter Memory Slave

This block is the slave end of a three-wire synchronous serial link: an active-low select, a clock driven by the host, and a data line that is split into an input, an output and an output-enable. It keeps a 32-bit count of seconds, taken from 1 January 1904, which advances on a one-pulse-per-second input. It also holds 256 bytes of parameter memory as on-chip registers. The serial clock and data are oversampled by the system clock, so the host must hold each serial clock level for at least two system clock cycles.

Each transaction opens with a command byte. Bit 7 of that byte is the direction flag, where 1 means read. The rest of the byte picks a seconds byte, a write-only control register, a directly addressed low memory byte, or a sector of the whole memory. Depending on the target, the transaction is one, two or three bytes long. A sticky protect flag blocks every write except a write to the protect flag itself. Read data goes back to the host MSB first, and the block ignores incoming bits until the last outgoing bit has been sent.

Top module: `serial_clock_pram`

## Requirements
- R1: After reset, sdo_oe is 0, every memory byte reads 0x00, protection is off and the seconds count equals SECS_INIT.
- R2: Commands z0000001, z0000101, z0001001 and z0001101 (z = bit 7, 1 for read) select seconds bytes 0 to 3. Byte 0 is bits 7..0 of the count and byte 3 is bits 31..24. A write replaces that one byte.
- R3: Each clock cycle with pps high adds one to the seconds count, with carry across all 32 bits.
- R4: Pattern z1aaaa01 addresses memory byte 0x0 to 0xF (aaaa). A write takes exactly one following data byte, and a read returns one byte straight away.
- R5: Pattern z010aa01 addresses memory byte 0x10 + aa.
- R6: Pattern z0111sss is the sector form. The next byte carries the offset in bits 6..2, and the address is sss*32 + offset. A read returns one byte after the offset byte. A write takes a third byte as data. The sector space aliases the direct addresses.
- R7: With protection on, every write command is dropped with its data, except a write of 0x35. A 0x35 write sets protection from bit 7 of its data byte.
- R8: Command 0x31 consumes exactly one data byte and changes nothing else.
- R9: A command byte that matches no pattern is dropped, and the next byte is taken as a new command. This includes 0xB1 and 0xB5, the read forms of the write-only registers, and any byte whose low two bits are not 01 outside the sector form.
- R10: While sel_n is high the serial logic is idle. Raising sel_n part way through a byte or a transaction discards the partial byte and any pending command.
- R11: sdo_oe is high only from the first outgoing bit until the falling serial clock edge after the eighth. Input bits are ignored for that whole time.
- R12: Input bits are sampled MSB first on rising sck edges. Output bits are presented MSB first, each one following a falling sck edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps | input | 1 | One-cycle pulse per second |
| sel_n | input | 1 | Active-low transaction select |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for sdo |

## Verification
The hardest states to reach are the pending ones that exist between bytes. These are a write command waiting for its data, a sector write waiting for its third byte, and the same states under protection, where a bad design would take the next byte in the wrong role. The stimulus deliberately leaves such a state pending and then either raises select or sends a read command in the slot where data would go. The scoreboard then sees either an extra returned byte or a missing one. Several commands are also chained inside one select to show that each target consumes exactly its own byte count.

// File: rtl/serial_clock_pram.sv
module serial_clock_pram #(
  parameter logic [31:0] SECS_INIT = 32'd0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps,
  input  logic sel_n,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {T_NONE, T_SEC, T_TEST, T_WP, T_RAM, T_EXT} tgt_t;

  logic [7:0]  ram [DEPTH];
  logic [31:0] secs;
  logic        wp;
  logic        sck_q;
  logic [2:0]  bcnt;
  logic [6:0]  acc;
  logic [1:0]  phase;
  tgt_t        ctgt, dtgt;
  logic [AW-1:0] cidx, didx;
  logic        crd;
  logic [4:0]  offs;
  logic [7:0]  oshift;
  logic [3:0]  ocnt;
  logic        oe_r, sdo_r;
  logic [6:0]  v;
  logic [4:0]  u;

  wire rise = !sel_n && sck && !sck_q;
  wire fall = !sel_n && !sck && sck_q;
  wire busy = (ocnt != 4'd0) || oe_r;
  wire [7:0] byte_in = {acc, sdi};
  wire byte_done = rise && !busy && (bcnt == 3'd7);

  assign sdo = sdo_r;
  assign sdo_oe = oe_r;

  always_comb begin
    v = byte_in[6:0];
    u = v[6:2];
    dtgt = T_NONE;
    didx = '0;
    if (v[6:3] == 4'b0111) begin
      dtgt = T_EXT;
      didx = {5'd0, v[2:0]};
    end else if (v[1:0] == 2'b01) begin
      if (u[4:2] == 3'b000) begin
        dtgt = T_SEC;
        didx = {6'd0, u[1:0]};
      end else if (u == 5'b01100) begin
        dtgt = byte_in[7] ? T_NONE : T_TEST;
      end else if (u == 5'b01101) begin
        dtgt = byte_in[7] ? T_NONE : T_WP;
      end else if (u[4:2] == 3'b010) begin
        dtgt = T_RAM;
        didx = {6'b000100, u[1:0]};
      end else if (u[4]) begin
        dtgt = T_RAM;
        didx = {4'd0, u[3:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= 8'h00;
      secs <= SECS_INIT;
      wp <= 1'b0;
      sck_q <= 1'b0;
      bcnt <= '0;
      acc <= '0;
      phase <= 2'd0;
      ctgt <= T_NONE;
      cidx <= '0;
      crd <= 1'b0;
      offs <= '0;
      oshift <= '0;
      ocnt <= '0;
      oe_r <= 1'b0;
      sdo_r <= 1'b0;
    end else begin
      sck_q <= sck;
      if (pps) secs <= secs + 32'd1;
      if (sel_n) begin
        bcnt <= '0;
        phase <= 2'd0;
        ocnt <= '0;
        oe_r <= 1'b0;
      end else begin
        if (fall) begin
          if (ocnt != 4'd0) begin
            sdo_r <= oshift[7];
            oshift <= {oshift[6:0], 1'b0};
            ocnt <= ocnt - 4'd1;
            oe_r <= 1'b1;
          end else begin
            oe_r <= 1'b0;
          end
        end
        if (rise && !busy) begin
          bcnt <= bcnt + 3'd1;
          acc <= byte_in[6:0];
        end
        if (byte_done) begin
          case (phase)
            2'd0: begin
              if (dtgt == T_EXT) begin
                if (byte_in[7] || !wp) begin
                  phase <= 2'd1; ctgt <= T_EXT; cidx <= didx; crd <= byte_in[7];
                end
              end else if (dtgt != T_NONE) begin
                if (byte_in[7]) begin
                  oshift <= (dtgt == T_SEC) ? secs[{didx[1:0], 3'b000} +: 8] : ram[didx];
                  ocnt <= 4'd8;
                end else if (!wp || dtgt == T_WP) begin
                  phase <= 2'd1; ctgt <= dtgt; cidx <= didx; crd <= 1'b0;
                end
              end
            end
            2'd1: begin
              phase <= 2'd0;
              case (ctgt)
                T_SEC: secs[{cidx[1:0], 3'b000} +: 8] <= byte_in;
                T_WP:  wp <= byte_in[7];
                T_RAM: ram[cidx] <= byte_in;
                T_EXT: begin
                  if (crd) begin
                    oshift <= ram[{cidx[2:0], byte_in[6:2]}];
                    ocnt <= 4'd8;
                  end else begin
                    offs <= byte_in[6:2];
                    phase <= 2'd2;
                  end
                end
                default: ;
              endcase
            end
            2'd2: begin
              ram[{cidx[2:0], offs}] <= byte_in;
              phase <= 2'd0;
            end
            default: phase <= 2'd0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/serial_clock_pram_chk.sv
module serial_clock_pram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_n,
  input logic        sck,
  input logic        sdo,
  input logic        sdo_oe,
  input logic        pps,
  input logic        byte_done,
  input logic        wp,
  input logic [31:0] secs
);
  logic c_sck, c_sel;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_sck <= 1'b0;
      c_sel <= 1'b1;
    end else begin
      c_sck <= sck;
      c_sel <= sel_n;
    end
  end

  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && c_sel) |-> !sdo_oe);

  // R12
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck == c_sck) |=> $stable(sdo));

  // R3
  secs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pps && !byte_done) |=> $stable(secs));

  // R7
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(wp));
endmodule

bind serial_clock_pram serial_clock_pram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdo(sdo),
  .sdo_oe(sdo_oe), .pps(pps), .byte_done(byte_done), .wp(wp), .secs(secs)
);

// File: tb/test_serial_clock_pram.sv
module test_serial_clock_pram;
  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0, sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk; // 4 ns period, 250 MHz

  serial_clock_pram i_serial_clock_pram (
    .clk(clk), .rst_n(rst_n), .pps(pps), .sel_n(sel_n), .sck(sck),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input bit ok, input string r, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  task automatic shift_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sck = 1'b0; sdi = b[i];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic shift(input logic [7:0] b);
    shift_bits(b, 8);
  endtask

  task automatic open_t();
    @(negedge clk); sel_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_t();
    @(negedge clk); sck = 1'b0;
    repeat (3) @(negedge clk);
    sel_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_read(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    shift(8'h00);
  endtask

  task automatic end_read();
    @(negedge clk); sck = 1'b0;
    repeat (3) @(negedge clk);
    check(sdo_oe == 1'b0, "R11 oe after last bit", sdo_oe, 0);
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    open_t(); shift(c); shift(d);
    check(sdo_oe == 1'b0, "R11 oe during write", sdo_oe, 0);
    close_t();
  endtask

  task automatic rd(input logic [7:0] c, input logic [7:0] e, input string tag);
    open_t(); shift(c); expect_read(e, tag); end_read(); close_t();
  endtask

  task automatic ext_wr(input logic [2:0] s, input logic [4:0] o, input logic [7:0] d);
    open_t(); shift({5'b00111, s}); shift({1'b0, o, 2'b00}); shift(d); close_t();
  endtask

  task automatic ext_rd(input logic [2:0] s, input logic [4:0] o, input logic [7:0] e, input string tag);
    open_t(); shift({5'b10111, s}); shift({1'b0, o, 2'b00}); expect_read(e, tag); end_read(); close_t();
  endtask

  // scoreboard monitor
  logic m_sck = 1'b0;
  int m_n = 0;
  logic [7:0] m_acc = 8'h00;
  initial forever begin
    @(posedge clk); #1;
    if (sel_n) m_n = 0;
    else if (sck && !m_sck && sdo_oe) begin
      m_acc = {m_acc[6:0], sdo};
      m_n++;
      if (m_n == 8) begin
        m_n = 0;
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected read byte", m_acc, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(m_acc == e, t, m_acc, e);
        end
      end
    end
    m_sck = sck;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sdo_oe == 1'b0, "R1 oe at reset", sdo_oe, 0);
    rd(8'hD5, 8'h00, "R1 ram reset");
    rd(8'h8D, 8'h00, "R1 seconds reset");

    wr(8'h01, 8'hFE); wr(8'h05, 8'hFF); wr(8'h09, 8'hFF); wr(8'h0D, 8'h12);
    rd(8'h81, 8'hFE, "R2 byte0"); rd(8'h85, 8'hFF, "R2 byte1");
    rd(8'h89, 8'hFF, "R2 byte2"); rd(8'h8D, 8'h12, "R2 byte3");

    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pps = 1'b1; @(negedge clk); pps = 1'b0; @(negedge clk);
    end
    rd(8'h81, 8'h01, "R3 carry byte0"); rd(8'h85, 8'h00, "R3 carry byte1");
    rd(8'h89, 8'h00, "R3 carry byte2"); rd(8'h8D, 8'h13, "R3 carry byte3");

    wr(8'h55, 8'hA5); rd(8'hD5, 8'hA5, "R4 addr 05");
    wr(8'h7D, 8'h3C); rd(8'hFD, 8'h3C, "R12 msb first addr 0F");
    wr(8'h41, 8'h11); rd(8'hC1, 8'h11, "R4 addr 00");

    wr(8'h29, 8'h77); rd(8'hA9, 8'h77, "R5 addr 12");
    wr(8'h2D, 8'h88); rd(8'hAD, 8'h88, "R5 addr 13");

    ext_wr(3'd6, 5'd21, 8'h5A); ext_rd(3'd6, 5'd21, 8'h5A, "R6 sector 6 off 21");
    ext_rd(3'd6, 5'd20, 8'h00, "R6 neighbour untouched");
    ext_rd(3'd0, 5'd5, 8'hA5, "R6 alias of direct 05");
    ext_wr(3'd0, 5'h11, 8'hC3); rd(8'hA5, 8'hC3, "R6 alias into direct 11");
    ext_rd(3'd7, 5'd31, 8'h00, "R6 last byte");

    wr(8'h35, 8'h80);
    wr(8'h55, 8'h00); rd(8'hD5, 8'hA5, "R7 direct write blocked");
    ext_wr(3'd6, 5'd21, 8'h00); ext_rd(3'd6, 5'd21, 8'h5A, "R7 sector write blocked");
    wr(8'h01, 8'h00); rd(8'h81, 8'h01, "R7 seconds write blocked");
    open_t(); shift(8'h55); shift(8'hD5); expect_read(8'hA5, "R7 dropped data not taken"); end_read(); close_t();
    wr(8'h35, 8'h7F);
    wr(8'h55, 8'h66); rd(8'hD5, 8'h66, "R7 unprotected by bit7=0");

    open_t(); shift(8'h31); shift(8'hFF); shift(8'hD5);
    expect_read(8'h66, "R8 test consumes one byte"); end_read(); close_t();
    open_t(); shift(8'h55); shift(8'h44); shift(8'hD5);
    expect_read(8'h44, "R4 one data byte"); end_read(); close_t();

    open_t(); shift(8'hB1); shift(8'hD5); expect_read(8'h44, "R9 after B1"); end_read(); close_t();
    open_t(); shift(8'hB5); shift(8'hFD); expect_read(8'h3C, "R9 after B5"); end_read(); close_t();
    open_t(); shift(8'h00); shift(8'hD5); expect_read(8'h44, "R9 after 00"); end_read(); close_t();

    open_t(); shift_bits(8'hFF, 4); close_t();
    rd(8'hD5, 8'h44, "R10 partial byte dropped");
    open_t(); shift(8'h55); close_t();
    rd(8'hD5, 8'h44, "R10 pending write dropped");
    open_t(); shift(8'h3E); shift(8'h54); close_t();
    rd(8'hD5, 8'h44, "R10 pending sector write dropped");
    ext_rd(3'd6, 5'd21, 8'h5A, "R10 sector byte intact");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule